// File: doc/BRIEF.md
# Fast Gate A20 Command Decoder

This block watches host writes into a keyboard-controller style input data port and drives the A20 address gate level in hardware. Each host write arrives with a channel number and a flag that marks it as a command byte or a data byte. Only writes on channel 1 are looked at. When the hardware path is switched on, the command 0xD1 arms the decoder. Bit 1 of the next data byte on that channel then becomes the new gate level. No firmware or interrupt is involved.

When the hardware path is switched off, a firmware-written register bit drives the gate. In that mode firmware handles the 0xD1 sequence itself. A status output always reflects the level that currently drives the gate.

Top module: `fast_a20_gate`

## Requirements
- R1: After reset, gate_out and gate_status are 1, the hardware path is off, the firmware gate bit is 1 and the decoder is idle.
- R2: While the hardware path is off, gate_out equals the firmware gate bit that was last written with cfg_we. Host writes have no effect on gate_out.
- R3: Writing cfg_fast_en=1 while the hardware path is off forces gate_out to 1 on the next clock edge, whatever the firmware bit holds. The decoder starts idle.
- R4: Host writes on any channel other than 1 never change gate_out and never arm or disarm the decoder.
- R5: With the hardware path on, a command write (host_is_cmd=1) of 0xD1 on channel 1 arms the decoder. The next data write (host_is_cmd=0) on channel 1 sets gate_out to host_data bit 1 one clock edge after its strobe.
- R6: A command write on channel 1 with any value other than 0xD1 leaves the decoder idle, even if it was armed.
- R7: A data write on channel 1 while the decoder is idle leaves gate_out unchanged.
- R8: Once a data byte has been applied to the gate, the decoder returns to idle. A further data byte has no effect until a new 0xD1 command arrives.
- R9: gate_status always equals gate_out.
- R10: Writing cfg_fast_en=0 disarms the decoder. From the next edge on, gate_out follows the firmware gate bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_chan | input | CHAN_W | Input data register channel of the write |
| host_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| host_data | input | DATA_W | Written byte |
| cfg_we | input | 1 | Firmware configuration write strobe |
| cfg_fast_en | input | 1 | New value of the hardware-path enable |
| cfg_fw_gate | input | 1 | New value of the firmware gate bit |
| gate_out | output | 1 | A20 gate level |
| gate_status | output | 1 | Readback of the gate level |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. This covers arming, gate updates, the forced 1 on enable and the handover to firmware. The bench drives each stimulus on a falling edge and holds it across one rising edge. It clears the strobes and compares both outputs against its model on the next falling edge, so each check sees the state one edge after its stimulus. The model applies the same one-edge rule. This includes cases where a configuration write and a host write fall in the same cycle.

// File: rtl/fast_a20_pkg.sv
package fast_a20_pkg;
  localparam int unsigned A20_DATA_W = 8;
  localparam logic [A20_DATA_W-1:0] A20_ARM_CMD = 8'hD1;

  typedef enum logic {
    DEC_IDLE  = 1'b0,
    DEC_ARMED = 1'b1
  } a20_dec_e;
endpackage

// File: rtl/a20_rst_sync.sv
module a20_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/a20_chan_filter.sv
module a20_chan_filter #(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned GATE_CHAN = 1
) (
  input  logic              host_wr,
  input  logic [CHAN_W-1:0] host_chan,
  input  logic              host_is_cmd,
  input  logic [DATA_W-1:0] host_data,
  input  logic              fast_en,
  input  logic [DATA_W-1:0] arm_value,
  output logic              cmd_arm,
  output logic              cmd_other,
  output logic              data_hit
);
  localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(GATE_CHAN);

  logic qualified;

  always_comb begin
    qualified = host_wr && fast_en && (host_chan == CHAN_SEL);
    cmd_arm   = qualified && host_is_cmd && (host_data == arm_value);
    cmd_other = qualified && host_is_cmd && (host_data != arm_value);
    data_hit  = qualified && !host_is_cmd;
  end
endmodule

// File: rtl/a20_cfg_reg.sv
module a20_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_fast_en,
  input  logic cfg_fw_gate,
  output logic fast_en_q,
  output logic fw_gate_q,
  output logic en_rise,
  output logic en_fall
);
  logic fast_en_d;
  logic fw_gate_d;

  always_comb begin
    fast_en_d = fast_en_q;
    fw_gate_d = fw_gate_q;
    if (cfg_we) begin
      fast_en_d = cfg_fast_en;
      fw_gate_d = cfg_fw_gate;
    end
    en_rise = cfg_we && cfg_fast_en && !fast_en_q;
    en_fall = cfg_we && !cfg_fast_en && fast_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_en_q <= 1'b0;
      fw_gate_q <= 1'b1;
    end else if (cfg_we) begin
      fast_en_q <= fast_en_d;
      fw_gate_q <= fw_gate_d;
    end
  end
endmodule

// File: rtl/a20_cmd_fsm.sv
module a20_cmd_fsm #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_arm,
  input  logic              cmd_other,
  input  logic              data_hit,
  input  logic [DATA_W-1:0] host_data,
  input  logic              en_rise,
  input  logic              en_fall,
  output logic              armed,
  output logic              hw_gate_q
);
  import fast_a20_pkg::*;

  a20_dec_e state_q, state_d;
  logic     hw_gate_d;
  logic     upd;

  always_comb begin
    state_d   = state_q;
    hw_gate_d = hw_gate_q;
    if (cmd_arm) begin
      state_d = DEC_ARMED;
    end else if (cmd_other) begin
      state_d = DEC_IDLE;
    end else if (data_hit && state_q == DEC_ARMED) begin
      hw_gate_d = host_data[GATE_BIT];
      state_d   = DEC_IDLE;
    end
    if (en_rise) begin
      hw_gate_d = 1'b1;
      state_d   = DEC_IDLE;
    end
    if (en_fall) begin
      state_d = DEC_IDLE;
    end
    upd = (state_d != state_q) || (hw_gate_d != hw_gate_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= DEC_IDLE;
      hw_gate_q <= 1'b1;
    end else if (upd) begin
      state_q   <= state_d;
      hw_gate_q <= hw_gate_d;
    end
  end

  assign armed = (state_q == DEC_ARMED);
endmodule

// File: rtl/fast_a20_gate.sv
module fast_a20_gate #(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned DATA_W    = fast_a20_pkg::A20_DATA_W,
  parameter int unsigned GATE_CHAN = 1,
  parameter int unsigned GATE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [CHAN_W-1:0] host_chan,
  input  logic              host_is_cmd,
  input  logic [DATA_W-1:0] host_data,
  input  logic              cfg_we,
  input  logic              cfg_fast_en,
  input  logic              cfg_fw_gate,
  output logic              gate_out,
  output logic              gate_status
);
  import fast_a20_pkg::*;

  localparam logic [DATA_W-1:0] ARM_VALUE = DATA_W'(A20_ARM_CMD);

  logic rst_sync_n;
  logic fast_en_q, fw_gate_q, en_rise, en_fall;
  logic cmd_arm, cmd_other, data_hit;
  logic armed, hw_gate_q;

  a20_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  a20_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_fast_en(cfg_fast_en),
    .cfg_fw_gate(cfg_fw_gate),
    .fast_en_q  (fast_en_q),
    .fw_gate_q  (fw_gate_q),
    .en_rise    (en_rise),
    .en_fall    (en_fall)
  );

  a20_chan_filter #(
    .CHAN_W   (CHAN_W),
    .DATA_W   (DATA_W),
    .GATE_CHAN(GATE_CHAN)
  ) u_filt (
    .host_wr    (host_wr),
    .host_chan  (host_chan),
    .host_is_cmd(host_is_cmd),
    .host_data  (host_data),
    .fast_en    (fast_en_q),
    .arm_value  (ARM_VALUE),
    .cmd_arm    (cmd_arm),
    .cmd_other  (cmd_other),
    .data_hit   (data_hit)
  );

  a20_cmd_fsm #(
    .DATA_W  (DATA_W),
    .GATE_BIT(GATE_BIT)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_arm  (cmd_arm),
    .cmd_other(cmd_other),
    .data_hit (data_hit),
    .host_data(host_data),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .armed    (armed),
    .hw_gate_q(hw_gate_q)
  );

  assign gate_out    = fast_en_q ? hw_gate_q : fw_gate_q;
  assign gate_status = gate_out;
endmodule

// File: rtl/fast_a20_gate_chk.sv
module fast_a20_gate_chk #(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned GATE_CHAN = 1,
  parameter int unsigned GATE_BIT  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [CHAN_W-1:0] host_chan,
  input logic              host_is_cmd,
  input logic [DATA_W-1:0] host_data,
  input logic              cfg_we,
  input logic              cfg_fast_en,
  input logic              fast_en,
  input logic              armed,
  input logic              gate_out
);
  localparam logic [CHAN_W-1:0] SEL = CHAN_W'(GATE_CHAN);

  assert_fw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_en && !cfg_we) |=> $stable(gate_out));

  assert_enable_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_fast_en && !fast_en) |=> (gate_out && !armed));

  assert_other_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && host_wr && host_chan != SEL && !cfg_we) |=> ($stable(gate_out) && $stable(armed)));

  assert_apply_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && armed && host_wr && host_chan == SEL && !host_is_cmd && !cfg_we)
      |=> (gate_out == $past(host_data[GATE_BIT])));

  assert_disarm_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && host_wr && host_chan == SEL && host_is_cmd && host_data != 8'hD1) |=> !armed);

  assert_idle_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !armed && !(host_wr && host_chan == SEL && host_is_cmd) && !cfg_we) |=> $stable(gate_out));

  assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && armed && host_wr && host_chan == SEL && !host_is_cmd) |=> !armed);

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_fast_en) |=> (!armed && !fast_en));
endmodule

bind fast_a20_gate fast_a20_gate_chk #(
  .CHAN_W   (CHAN_W),
  .DATA_W   (DATA_W),
  .GATE_CHAN(GATE_CHAN),
  .GATE_BIT (GATE_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_wr    (host_wr),
  .host_chan  (host_chan),
  .host_is_cmd(host_is_cmd),
  .host_data  (host_data),
  .cfg_we     (cfg_we),
  .cfg_fast_en(cfg_fast_en),
  .fast_en    (fast_en_q),
  .armed      (armed),
  .gate_out   (gate_out)
);

// File: tb/tb_fast_a20_gate.sv
module tb_fast_a20_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CHAN_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [CHAN_W-1:0] host_chan = '0;
  logic host_is_cmd = 1'b0;
  logic [7:0] host_data = '0;
  logic cfg_we = 1'b0;
  logic cfg_fast_en = 1'b0;
  logic cfg_fw_gate = 1'b0;
  logic gate_out, gate_status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  bit m_fast, m_fw, m_hw, m_armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_a20_gate dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_chan(host_chan),
    .host_is_cmd(host_is_cmd), .host_data(host_data), .cfg_we(cfg_we),
    .cfg_fast_en(cfg_fast_en), .cfg_fw_gate(cfg_fw_gate),
    .gate_out(gate_out), .gate_status(gate_status)
  );

  function automatic bit exp_gate();
    return m_fast ? m_hw : m_fw;
  endfunction

  function automatic void model_step();
    if (host_wr && m_fast && host_chan == 2'd1) begin
      if (host_is_cmd) m_armed = (host_data == 8'hD1);
      else if (m_armed) begin
        m_hw = host_data[1];
        m_armed = 1'b0;
      end
    end
    if (cfg_we) begin
      if (cfg_fast_en && !m_fast) begin
        m_hw = 1'b1;
        m_armed = 1'b0;
      end
      if (!cfg_fast_en) m_armed = 1'b0;
      m_fast = cfg_fast_en;
      m_fw = cfg_fw_gate;
    end
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (gate_out !== exp_gate() || gate_status !== exp_gate()) begin
      n_fail++;
      $display("FAIL %s: gate_out=%b gate_status=%b expected %b", tag, gate_out, gate_status, exp_gate());
    end
  endtask

  // called at a falling edge with inputs set; one edge later the result is checked
  task automatic apply(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    host_wr = 1'b0;
    cfg_we = 1'b0;
    check(tag);
  endtask

  task automatic host(input logic [1:0] ch, input bit cmd, input logic [7:0] d, input string tag);
    host_wr = 1'b1; host_chan = ch; host_is_cmd = cmd; host_data = d;
    apply(tag);
  endtask

  task automatic cfg(input bit fast, input bit gate, input string tag);
    cfg_we = 1'b1; cfg_fast_en = fast; cfg_fw_gate = gate;
    apply(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h0A20);
    m_fast = 0; m_fw = 1; m_hw = 1; m_armed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state");

    // R2: fast off, host sequence ignored, firmware bit drives
    host(2'd1, 1'b1, 8'hD1, "R2 host cmd ignored");
    host(2'd1, 1'b0, 8'h00, "R2 host data ignored");
    cfg(1'b0, 1'b0, "R2 firmware bit 0");
    cfg(1'b0, 1'b1, "R2 firmware bit 1");
    cfg(1'b0, 1'b0, "R2 firmware bit 0 again");
    // R3
    cfg(1'b1, 1'b0, "R3 enable forces 1");
    // R5 / R8
    host(2'd1, 1'b1, 8'hD1, "R5 arm");
    host(2'd1, 1'b0, 8'hFD, "R5 data bit1=0");
    host(2'd1, 1'b0, 8'h02, "R8 second data ignored");
    host(2'd1, 1'b1, 8'hD1, "R5 re-arm");
    host(2'd1, 1'b0, 8'h02, "R5 data bit1=1");
    host(2'd1, 1'b1, 8'hD1, "R5 arm again");
    host(2'd1, 1'b0, 8'h00, "R5 data to 0");
    // R6
    host(2'd1, 1'b1, 8'hD1, "R6 arm");
    host(2'd1, 1'b1, 8'hD0, "R6 other cmd");
    host(2'd1, 1'b0, 8'h02, "R6 data after disarm");
    // R7
    host(2'd1, 1'b0, 8'hFF, "R7 data while idle");
    // R4
    host(2'd2, 1'b1, 8'hD1, "R4 other chan cmd");
    host(2'd1, 1'b0, 8'h02, "R4 data not armed");
    host(2'd1, 1'b1, 8'hD1, "R4 arm chan1");
    host(2'd0, 1'b1, 8'h00, "R4 chan0 cmd no disarm");
    host(2'd3, 1'b0, 8'h02, "R4 chan3 data ignored");
    host(2'd1, 1'b0, 8'h02, "R4 still armed applies");
    // R10
    host(2'd1, 1'b1, 8'hD1, "R10 arm");
    cfg(1'b0, 1'b0, "R10 firmware takes over");
    cfg(1'b0, 1'b1, "R10 firmware bit 1");
    cfg(1'b1, 1'b0, "R3 re-enable forces 1");
    host(2'd1, 1'b0, 8'h00, "R10 disarmed by disable");

    // random mix, R9 checks status against gate every step
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 5) begin
        host_wr = 1'b1; host_chan = 2'd1;
        host_is_cmd = $urandom_range(0, 1);
        host_data = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'hD1;
        if (!host_is_cmd) host_data = 8'($urandom);
      end else if (op == 6) begin
        host_wr = 1'b1; host_chan = 2'($urandom_range(0, 3));
        host_is_cmd = $urandom_range(0, 1); host_data = 8'($urandom);
      end else if (op == 7) begin
        cfg_we = 1'b1; cfg_fast_en = ($urandom_range(0, 3) != 0);
        cfg_fw_gate = $urandom_range(0, 1);
        if ($urandom_range(0, 3) == 0) begin
          host_wr = 1'b1; host_chan = 2'd1; host_is_cmd = 1'b0; host_data = 8'($urandom);
        end
      end
      apply("R9 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule